// File: doc/BRIEF.md
# UART Data Register Access Logic

This block is the bus-facing register slice of a UART. A simple CPU bus (address, read strobe, write strobe, byte data) reaches three registers: a status register, a control register and a shared data location. A read at the data location returns the receive holding register. A write at the data location loads the transmit holding register. The serial engines, the baud timing and the receive buffer all sit outside this block. It takes words from the receiver, sees the buffer fill level, and passes a 9-bit word plus a load pulse to the transmitter.

Frames can be 8 or 9 bits long. The ninth transmit bit is written first to a staging bit in the control register. It reaches the transmitter only when the data location is written. A data read clears the receive-full flag, but only when the buffer level is below a watermark. The parity-error flag needs a status read first and then a data read. A control bit enables the parity-error interrupt request.

Top module: `uart_dreg_if`

## Requirements
- R1: Address 2 is the data location. A read there returns the low 8 bits of the receive holding register unchanged, so in 8-bit mode with parity the parity bit stays in bit 7. A write there loads the transmit side.
- R2: A write to address 2 sets `tx_word` to {staged ninth bit, write byte} and raises `tx_load` for the single cycle after the write edge.
- R3: A write to control address 1 stores bit 6 in the staging bit and bit 0 as the parity interrupt enable. It leaves `tx_word` unchanged and raises no `tx_load`.
- R4: A data write with no fresh control write before it reuses the staging bit from the last control write. Every data write consumes the staging bit, and the staging bit stays as it is.
- R5: An `rx_push` loads `rx_word` into the receive holding register and sets the receive-full flag (status address 0, bit 0). A push wins over a clear in the same cycle.
- R6: A data read clears the receive-full flag when `rx_wmark` is 0 or `rx_level` < `rx_wmark`. Otherwise the flag stays set. `rx_pop` pulses during every data read.
- R7: A read of control address 1 returns {received ninth bit, staging bit, 5'b0, enable} in bits 7, 6 and 0. It changes no flag.
- R8: A push with `rx_perr` high sets the parity-error flag (status bit 1). A data read clears it only if a status read came after the latest push. Control reads between the two do not break the sequence.
- R9: `irq_perr` is high exactly when the parity-error flag and the enable are both 1. It follows them in the same cycle.
- R10: With `mode9` low, `tx_word[8]` is committed as 0 and control bit 7 reads 0.
- R11: After reset the staging bit, `tx_word`, the enable, both flags and `tx_load` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode9 | input | 1 | 1 selects 9-bit frames |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| rx_push | input | 1 | Receiver delivers a word |
| rx_word | input | 9 | Received word |
| rx_perr | input | 1 | Parity error on the pushed word |
| rx_level | input | LVL_W | Receive buffer fill level |
| rx_wmark | input | LVL_W | Receive watermark |
| rx_pop | output | 1 | Data read in progress |
| tx_word | output | 9 | Committed transmit word |
| tx_load | output | 1 | Transmit word newly committed |
| irq_perr | output | 1 | Parity-error interrupt request |

## Verification
The hardest case to reach is a data read that must not clear a flag for a reason invisible at that moment. The watermark may block the receive-full clear. The parity-error clear may lack an arming status read, or a later push may have cancelled that arming. Random stimulus mixes pushes, reads of all three addresses and watermark/level settings on every step, so stale arming and blocked clears come up often. Directed sequences also force each case once: blocked and allowed watermark reads, a push between the status read and the data read, and a data write with a stale staging bit.

// File: rtl/uart_dreg_pkg.sv
package uart_dreg_pkg;
   localparam int STAT_OFS = 0;
   localparam int CTRL_OFS = 1;
   localparam int DATA_OFS = 2;
   localparam int CTRL_RX8_BIT = 7;
   localparam int CTRL_TX8_BIT = 6;
   localparam int CTRL_IE_BIT  = 0;
   localparam int STAT_FULL_BIT = 0;
   localparam int STAT_PERR_BIT = 1;
endpackage

// File: rtl/uart_dreg_decode.sv
module uart_dreg_decode #(
   parameter int ADDR_W = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   output logic              stat_rd,
   output logic              ctrl_rd,
   output logic              data_rd,
   output logic              ctrl_wr,
   output logic              data_wr
);
   import uart_dreg_pkg::*;
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);

   always_comb begin
      stat_rd = rd && (addr == A_STAT);
      ctrl_rd = rd && (addr == A_CTRL);
      data_rd = rd && (addr == A_DATA);
      ctrl_wr = wr && (addr == A_CTRL);
      data_wr = wr && (addr == A_DATA);
   end
endmodule

// File: rtl/uart_dreg_ctrl.sv
module uart_dreg_ctrl #(
   parameter bit SUPPORT9 = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode9,
   input  logic       ctrl_wr,
   input  logic       data_wr,
   input  logic [7:0] wdata,
   output logic       stage8_q,
   output logic       ie_q,
   output logic [8:0] tx_word,
   output logic       tx_load
);
   import uart_dreg_pkg::*;
   logic       ninth_commit;
   logic [7:0] tx_low_q;
   logic       tx_hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q     <= 1'b0;
         tx_low_q <= '0;
         tx_load  <= 1'b0;
      end else begin
         tx_load <= data_wr;
         if (ctrl_wr) ie_q <= wdata[CTRL_IE_BIT];
         if (data_wr) tx_low_q <= wdata;
      end
   end

   generate
      if (SUPPORT9) begin : g_ninth
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage8_q <= 1'b0;
               tx_hi_q  <= 1'b0;
            end else begin
               if (ctrl_wr) stage8_q <= wdata[CTRL_TX8_BIT];
               if (data_wr) tx_hi_q  <= ninth_commit;
            end
         end
         assign ninth_commit = stage8_q & mode9;
      end else begin : g_no_ninth
         assign stage8_q     = 1'b0;
         assign tx_hi_q      = 1'b0;
         assign ninth_commit = 1'b0;
      end
   endgenerate

   assign tx_word = {tx_hi_q, tx_low_q};
endmodule

// File: rtl/uart_dreg_rxflags.sv
module uart_dreg_rxflags #(
   parameter int LVL_W    = 4,
   parameter bit SUPPORT9 = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stat_rd,
   input  logic             data_rd,
   input  logic             rx_push,
   input  logic [8:0]       rx_word,
   input  logic             rx_perr,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] rx_wmark,
   output logic [8:0]       rx_q,
   output logic             full_q,
   output logic             perr_q
);
   logic arm_q;
   logic wm_ok;

   assign wm_ok = (rx_wmark == '0) || (rx_level < rx_wmark);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q[7:0] <= '0;
         full_q    <= 1'b0;
         perr_q    <= 1'b0;
         arm_q     <= 1'b0;
      end else begin
         if (rx_push) begin
            rx_q[7:0] <= rx_word[7:0];
            full_q    <= 1'b1;
            if (rx_perr) perr_q <= 1'b1;
            arm_q <= 1'b0;
         end else begin
            if (data_rd && wm_ok) full_q <= 1'b0;
            if (data_rd && arm_q) perr_q <= 1'b0;
            if (stat_rd)      arm_q <= 1'b1;
            else if (data_rd) arm_q <= 1'b0;
         end
      end
   end

   generate
      if (SUPPORT9) begin : g_rx9
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       rx_q[8] <= 1'b0;
            else if (rx_push) rx_q[8] <= rx_word[8];
         end
      end else begin : g_rx8
         assign rx_q[8] = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/uart_dreg_if.sv
module uart_dreg_if #(
   parameter int ADDR_W   = 2,
   parameter int LVL_W    = 4,
   parameter bit SUPPORT9 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode9,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              rx_push,
   input  logic [8:0]        rx_word,
   input  logic              rx_perr,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic [LVL_W-1:0]  rx_wmark,
   output logic              rx_pop,
   output logic [8:0]        tx_word,
   output logic              tx_load,
   output logic              irq_perr
);
   import uart_dreg_pkg::*;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("uart_dreg_if: ADDR_W must be at least 2");
      end
      if (LVL_W < 1) begin : g_bad_lvl
         $error("uart_dreg_if: LVL_W must be at least 1");
      end
   endgenerate

   logic       stat_rd, ctrl_rd, data_rd, ctrl_wr, data_wr;
   logic       stage8_q, ie_q, full_q, perr_q;
   logic [8:0] rx_q;

   uart_dreg_decode #(.ADDR_W(ADDR_W)) dec_i (
      .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
      .stat_rd(stat_rd), .ctrl_rd(ctrl_rd), .data_rd(data_rd),
      .ctrl_wr(ctrl_wr), .data_wr(data_wr)
   );

   uart_dreg_ctrl #(.SUPPORT9(SUPPORT9)) ctl_i (
      .clk(clk), .rst_n(rst_n), .mode9(mode9),
      .ctrl_wr(ctrl_wr), .data_wr(data_wr), .wdata(bus_wdata),
      .stage8_q(stage8_q), .ie_q(ie_q),
      .tx_word(tx_word), .tx_load(tx_load)
   );

   uart_dreg_rxflags #(.LVL_W(LVL_W), .SUPPORT9(SUPPORT9)) rxf_i (
      .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_rd(data_rd),
      .rx_push(rx_push), .rx_word(rx_word), .rx_perr(rx_perr),
      .rx_level(rx_level), .rx_wmark(rx_wmark),
      .rx_q(rx_q), .full_q(full_q), .perr_q(perr_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (stat_rd) begin
         bus_rdata[STAT_FULL_BIT] = full_q;
         bus_rdata[STAT_PERR_BIT] = perr_q;
      end else if (ctrl_rd) begin
         bus_rdata[CTRL_RX8_BIT] = rx_q[8] & mode9;
         bus_rdata[CTRL_TX8_BIT] = stage8_q;
         bus_rdata[CTRL_IE_BIT]  = ie_q;
      end else if (data_rd) begin
         bus_rdata = rx_q[7:0];
      end
   end

   assign rx_pop   = data_rd;
   assign irq_perr = perr_q & ie_q;
endmodule

// File: rtl/uart_dreg_chk.sv
module uart_dreg_chk #(
   parameter int ADDR_W = 2,
   parameter int LVL_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode9,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [7:0]        bus_wdata,
   input logic              rx_push,
   input logic [LVL_W-1:0]  rx_level,
   input logic [LVL_W-1:0]  rx_wmark,
   input logic [8:0]        tx_word,
   input logic              tx_load,
   input logic              irq_perr,
   input logic              full_q,
   input logic              ie_q
);
   logic dwr, cwr, drd;
   assign dwr = bus_wr && (bus_addr == ADDR_W'(2));
   assign cwr = bus_wr && (bus_addr == ADDR_W'(1));
   assign drd = bus_rd && (bus_addr == ADDR_W'(2));

   // R2
   data_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dwr |=> (tx_load && tx_word[7:0] == $past(bus_wdata)));
   // R3
   ctrl_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cwr && !dwr) |=> ($stable(tx_word) && !tx_load));
   // R5
   push_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> full_q);
   // R6
   wmark_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drd && !rx_push && rx_wmark != '0 && rx_level >= rx_wmark) |=> $stable(full_q));
   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_q |-> !irq_perr);
   // R10
   eight_bit_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dwr && !mode9) |=> !tx_word[8]);
endmodule

bind uart_dreg_if uart_dreg_chk #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .mode9(mode9), .bus_addr(bus_addr),
   .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
   .rx_push(rx_push), .rx_level(rx_level), .rx_wmark(rx_wmark),
   .tx_word(tx_word), .tx_load(tx_load), .irq_perr(irq_perr),
   .full_q(full_q), .ie_q(ie_q)
);

// File: tb/uart_dreg_if_tb_top.sv
module uart_dreg_if_tb_top;
   localparam int ADDR_W = 2;
   localparam int LVL_W  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mode9 = 1'b1;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0]        bus_wdata = '0;
   logic [7:0]        bus_rdata;
   logic              rx_push = 1'b0;
   logic [8:0]        rx_word = '0;
   logic              rx_perr = 1'b0;
   logic [LVL_W-1:0]  rx_level = '0, rx_wmark = '0;
   logic              rx_pop;
   logic [8:0]        tx_word;
   logic              tx_load, irq_perr;

   int checks = 0, errors = 0;

   logic       e_full = 0, e_perr = 0, e_arm = 0, e_tmp = 0, e_ie = 0;
   logic [8:0] e_rx = '0, e_tx = '0;

   always #10 clk = ~clk;

   uart_dreg_if #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) dut_i (.*);

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic wm_ok(input logic [LVL_W-1:0] lv, input logic [LVL_W-1:0] wm);
      return (wm == 0) || (lv < wm);
   endfunction

   function automatic logic [7:0] exp_ctrl();
      return {e_rx[8] & mode9, e_tmp, 5'b0, e_ie};
   endfunction

   task automatic step_end(input string req);
      @(posedge clk);
      @(negedge clk);
      bus_rd = 0; bus_wr = 0; rx_push = 0; rx_perr = 0;
      #1;
      check({req, " irq"}, 16'(irq_perr), 16'(e_perr & e_ie));
   endtask

   task automatic rd(input int a, input string req);
      logic [7:0] exp;
      bus_addr = ADDR_W'(a); bus_rd = 1;
      #1;
      case (a)
         0: begin exp = {6'b0, e_perr, e_full}; e_arm = 1; end
         1: exp = exp_ctrl();
         default: begin
            exp = e_rx[7:0];
            check({req, " pop"}, 16'(rx_pop), 16'd1);
            if (wm_ok(rx_level, rx_wmark)) e_full = 0;
            if (e_arm) e_perr = 0;
            e_arm = 0;
         end
      endcase
      check({req, " rdata"}, 16'(bus_rdata), 16'(exp));
      step_end(req);
      check({req, " no load"}, 16'(tx_load), 16'd0);
   endtask

   task automatic wr(input int a, input logic [7:0] d, input string req);
      bus_addr = ADDR_W'(a); bus_wr = 1; bus_wdata = d;
      if (a == 1) begin e_tmp = d[6]; e_ie = d[0]; end
      if (a == 2) e_tx = {e_tmp & mode9, d};
      step_end(req);
      check({req, " tx_word"}, 16'(tx_word), 16'(e_tx));
      check({req, " tx_load"}, 16'(tx_load), 16'(a == 2));
   endtask

   task automatic push(input logic [8:0] w, input logic pe, input string req);
      rx_push = 1; rx_word = w; rx_perr = pe;
      e_rx = w; e_full = 1; e_arm = 0;
      if (pe) e_perr = 1;
      step_end(req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R11 reset state
      check("R11 tx_word", 16'(tx_word), 16'd0);
      check("R11 tx_load", 16'(tx_load), 16'd0);
      check("R11 irq", 16'(irq_perr), 16'd0);
      rd(0, "R11 status");
      rd(1, "R11 ctrl");

      // R3 / R2 / R4 ninth-bit staging
      wr(1, 8'h40, "R3 stage");
      wr(2, 8'hA5, "R2 commit");
      wr(2, 8'h3C, "R4 reuse stage");
      wr(1, 8'h00, "R3 unstage");
      wr(2, 8'hFF, "R4 reuse zero");
      // R10 8-bit mode
      mode9 = 0;
      wr(1, 8'h40, "R10 stage");
      wr(2, 8'h11, "R10 commit");
      push(9'h1C3, 0, "R10 push");
      rd(1, "R10 ctrl");
      mode9 = 1;
      rd(1, "R7 ctrl nine");
      // R1 parity bit in bit 7 kept
      push(9'h080, 0, "R1 push");
      rd(2, "R1 data");
      // R6 watermark
      rx_wmark = 4; rx_level = 5;
      push(9'h012, 0, "R5 push");
      rd(2, "R6 blocked");
      rd(0, "R6 still full");
      rx_level = 3;
      rd(2, "R6 allowed");
      rx_wmark = 0; rx_level = 15;
      push(9'h034, 0, "R5 push2");
      rd(2, "R6 wm zero");
      rd(0, "R6 cleared");
      // R8 / R9 parity flag sequence
      wr(1, 8'h01, "R9 enable");
      push(9'h055, 1, "R8 push perr");
      rd(2, "R8 data no status");
      rd(1, "R7 ctrl no clear");
      rd(0, "R8 status");
      push(9'h066, 0, "R8 push disarm");
      rd(2, "R8 disarmed");
      rd(0, "R8 status2");
      rd(1, "R8 ctrl between");
      rd(2, "R8 cleared");
      push(9'h077, 1, "R9 perr again");
      wr(1, 8'h00, "R9 disable");
      wr(1, 8'h01, "R9 re-enable");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int op;
         op = $urandom_range(0, 9);
         rx_level = LVL_W'($urandom);
         rx_wmark = ($urandom_range(0, 3) == 0) ? '0 : LVL_W'($urandom);
         if ($urandom_range(0, 15) == 0) mode9 = ~mode9;
         case (op)
            0, 1: push(9'($urandom), ($urandom_range(0, 2) == 0), "R5 rand push");
            2, 3: rd(0, "R8 rand status");
            4:    rd(1, "R7 rand ctrl");
            5, 6: rd(2, "R6 rand data");
            7:    wr(1, 8'($urandom), "R3 rand ctrl");
            default: wr(2, 8'($urandom), "R2 rand data");
         endcase
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule